// File: doc/BRIEF.md
# SPI Transmit Queue with Threshold Interrupt

This block sits between a processor-side register bus and an SPI shift engine. Software writes data words through a dedicated push port into a 16-entry queue. The shifter takes words from the head of the queue through a valid/ready handshake. A single 16-bit control and status word holds the configuration: channel reset, queue-mode select, queue reset, interrupt enable and an occupancy threshold. Reading it also returns the live fill count and a latched interrupt flag. The flag latches whenever occupancy is at or below the threshold. Software clears it by writing one to a clear bit. The interrupt pin is the flag gated by the enable.

Four states control the queue. The state register loads on the same edge as the control word that selects it, in this priority: ST_CHRST when bit 15 is 0, else ST_HOLD when bit 13 is 0, else ST_DEEP when bit 14 is 1, else ST_SINGLE. Either reset state (ST_CHRST or ST_HOLD) empties the queue on entry, keeps it empty and clears the overflow indication. Leaving a reset state starts the queue empty in ST_SINGLE or ST_DEEP. A transition between ST_SINGLE and ST_DEEP empties the queue. In ST_SINGLE the queue holds one word. In ST_DEEP it holds sixteen.

Top module: `spi_txq_ctrl`

## Requirements
- R1: While reset is held, the control word reads 0xA000, and fill_level, tx_valid, ovf and irq are all 0. The first clock after reset sets the flag, because a fill of 0 is at or below the threshold of 0, so the word then reads 0xA080.
- R2: A write loads bit 15 (channel run, active low reset), bit 14 (deep mode), bit 13 (queue run, active low reset), bit 5 (interrupt enable) and bits 4:0 (threshold). Written values of bits 12:8 and bit 7 are ignored, and bit 6 always reads 0.
- R3: Bits 12:8 of the control word always equal fill_level, the number of words held.
- R4: In ST_DEEP the queue holds up to 16 words. The fill count rises by one for each accepted push, falls by one for each pop, and is unchanged when a push and a pop happen in the same cycle.
- R5: While bit 13 is 0, the fill count is 0, tx_valid is 0 and pushes are ignored. The queue starts empty once bit 13 is written back to 1.
- R6: While bit 15 is 0, the queue is empty, tx_valid is 0 and pushes are ignored. Bits 14, 13, 5 and 4:0 keep their written values.
- R7: The flag (bit 7) sets one clock after a cycle in which the fill count is at or below the threshold, whatever the enable. Once set, it stays set until cleared.
- R8: A write with bit 6 set clears the flag at that clock edge. If the condition still holds, the flag sets again on the following edge. A write with bit 6 clear leaves the flag as it is.
- R9: irq equals the flag ANDed with bit 5.
- R10: In ST_SINGLE the queue holds at most one word, so the fill count is only ever 0 or 1.
- R11: A push while the fill count equals the capacity (16 in ST_DEEP, 1 in ST_SINGLE) is dropped, even if a pop happens in the same cycle. A dropped push sets ovf, which stays set until bit 15 or bit 13 is written to 0.
- R12: A write that changes bit 14 while both resets are released empties the queue.
- R13: tx_valid is 1 exactly when a run state holds at least one word. tx_data is the oldest word held, so words leave in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_en | input | 1 | Control word write strobe |
| csr_wdata | input | 16 | Control word write data |
| csr_rdata | output | 16 | Control and status word readback |
| push_en | input | 1 | Push a data word into the queue |
| push_data | input | DATA_W | Data word to push |
| tx_valid | output | 1 | Head word available to the shifter |
| tx_ready | input | 1 | Shifter takes the head word |
| tx_data | output | DATA_W | Head word of the queue |
| fill_level | output | 5 | Number of words held |
| ovf | output | 1 | Sticky dropped-push indication |
| irq | output | 1 | Threshold interrupt |

## Verification
The assertions are checked on every cycle. They cover these properties: the fill count never exceeds the depth, or one word in ST_SINGLE. Any reset or mode flush leaves the queue empty on the next cycle. The overflow indication stays set until a reset state is entered. A clear write always lowers the flag, and the threshold condition with no clear always raises it. Only the bench's scenarios can show the following. Words leave in the order they were pushed. Configuration fields survive a channel reset. A push against a full queue is dropped even when a pop happens in the same cycle. The flag is correct for every pair of threshold and fill level from 0 to 16, which the bench sweeps against its own arithmetic model.

// File: rtl/spi_txq_pkg.sv
`timescale 1ns/1ps
package spi_txq_pkg;

    // Queue operating states, ordered by nothing: selection is by priority.
    typedef enum logic [1:0] {
        ST_CHRST  = 2'd0,
        ST_HOLD   = 2'd1,
        ST_SINGLE = 2'd2,
        ST_DEEP   = 2'd3
    } txq_state_e;

    localparam int CSR_W       = 16;
    localparam int FILL_W      = 5;
    localparam int THR_W       = 5;
    localparam int BIT_CHRUN   = 15;
    localparam int BIT_DEEP    = 14;
    localparam int BIT_QRUN    = 13;
    localparam int FILL_MSB    = 12;
    localparam int FILL_LSB    = 8;
    localparam int BIT_FLAG    = 7;
    localparam int BIT_CLR     = 6;
    localparam int BIT_IEN     = 5;
    localparam int THR_MSB     = THR_W - 1;

    function automatic logic state_runs(input txq_state_e s);
        return (s == ST_SINGLE) || (s == ST_DEEP);
    endfunction

endpackage

// File: rtl/spi_txq_csr.sv
`timescale 1ns/1ps
module spi_txq_csr
    import spi_txq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CSR_W-1:0]  wdata,
    input  logic [FILL_W-1:0] fill,
    output logic [CSR_W-1:0]  rdata,
    output logic              irq,
    output txq_state_e        state_q,
    output logic              q_clear,
    output logic              q_ovf_clr
);

    logic             chrun_q, chrun_d;
    logic             deep_q,  deep_d;
    logic             qrun_q,  qrun_d;
    logic             ien_q,   ien_d;
    logic [THR_W-1:0] thr_q,   thr_d;
    logic             flag_q,  flag_d;
    logic             clr_hit;
    logic             thr_hit;
    logic             flush;
    txq_state_e       state_d;

    // Next configuration: a write loads every writable field at once.
    always_comb begin
        chrun_d = chrun_q;
        deep_d  = deep_q;
        qrun_d  = qrun_q;
        ien_d   = ien_q;
        thr_d   = thr_q;
        if (wr_en) begin
            chrun_d = wdata[BIT_CHRUN];
            deep_d  = wdata[BIT_DEEP];
            qrun_d  = wdata[BIT_QRUN];
            ien_d   = wdata[BIT_IEN];
            thr_d   = wdata[THR_MSB:0];
        end
    end

    // Threshold flag: clear wins at its edge, condition re-arms after.
    always_comb begin
        clr_hit = wr_en && wdata[BIT_CLR];
        thr_hit = (fill <= thr_q);
        flag_d  = clr_hit ? 1'b0 : (flag_q | thr_hit);
    end

    // Next state, chosen by priority from the next configuration.
    always_comb begin
        if (!chrun_d) begin
            state_d = ST_CHRST;
        end else if (!qrun_d) begin
            state_d = ST_HOLD;
        end else if (deep_d) begin
            state_d = ST_DEEP;
        end else begin
            state_d = ST_SINGLE;
        end
    end

    // Mode flip between the two run states flushes the queue.
    always_comb begin
        unique case (state_q)
            ST_SINGLE: flush = (state_d == ST_DEEP);
            ST_DEEP:   flush = (state_d == ST_SINGLE);
            ST_CHRST:  flush = 1'b0;
            ST_HOLD:   flush = 1'b0;
            default:   flush = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chrun_q <= 1'b1;
            deep_q  <= 1'b0;
            qrun_q  <= 1'b1;
            ien_q   <= 1'b0;
            thr_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            chrun_q <= chrun_d;
            deep_q  <= deep_d;
            qrun_q  <= qrun_d;
            ien_q   <= ien_d;
            thr_q   <= thr_d;
            flag_q  <= flag_d;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SINGLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        rdata = {chrun_q, deep_q, qrun_q, fill, flag_q, 1'b0, ien_q, thr_q};
        irq   = flag_q & ien_q;
        q_ovf_clr = (state_d == ST_CHRST) || (state_d == ST_HOLD);
        q_clear   = q_ovf_clr || flush;
    end

    // R8: a clear write always lowers the flag at that edge
    a_r8_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[BIT_CLR]) |=> !flag_q);

    // R7: condition without a clear raises the flag on the next edge
    a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wdata[BIT_CLR]) && (fill <= thr_q)) |=> flag_q);

    // R7: the flag is sticky unless cleared
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_en && wdata[BIT_CLR])) |=> flag_q);

    // R6: a held channel reset keeps the block in ST_CHRST
    a_r6_chrst_state: assert property (@(posedge clk) disable iff (!rst_n)
        !chrun_q |-> (state_q == ST_CHRST));

endmodule

// File: rtl/spi_txq_store.sv
`timescale 1ns/1ps
module spi_txq_store
    import spi_txq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  txq_state_e        state_q,
    input  logic              q_clear,
    input  logic              q_ovf_clr,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_data,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic [FILL_W-1:0] fill,
    output logic              ovf
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [FILL_W-1:0] CAP_DEEP   = FILL_W'(DEPTH);
    localparam logic [FILL_W-1:0] CAP_SINGLE = FILL_W'(1);
    localparam logic [PTR_W-1:0]  PTR_LAST   = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [FILL_W-1:0] fill_q;
    logic              ovf_q;
    logic              run;
    logic [FILL_W-1:0] cap;
    logic              room;
    logic              push_ok;
    logic              drop;
    logic              pop_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        run      = state_runs(state_q);
        cap      = (state_q == ST_DEEP) ? CAP_DEEP : CAP_SINGLE;
        room     = (fill_q < cap);
        push_ok  = run && push_en && room;
        drop     = run && push_en && !room;
        tx_valid = run && (fill_q != '0);
        pop_ok   = tx_valid && tx_ready;
        tx_data  = mem_q[rd_ptr_q];
        fill     = fill_q;
        ovf      = ovf_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            fill_q   <= '0;
        end else if (q_clear) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            fill_q   <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
            if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
            fill_q <= fill_q + FILL_W'(push_ok) - FILL_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !q_clear) begin
            mem_q[wr_ptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (q_ovf_clr) begin
            ovf_q <= 1'b0;
        end else if (drop) begin
            ovf_q <= 1'b1;
        end
    end

    // R4: occupancy never exceeds the depth
    a_r4_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CAP_DEEP);

    // R10: single-word mode never holds more than one word
    a_r10_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SINGLE) |-> (fill_q <= CAP_SINGLE));

    // R5: any reset or flush leaves the queue empty and idle
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        q_clear |=> ((fill_q == '0) && !tx_valid));

    // R11: overflow stays set until a reset state clears it
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !q_ovf_clr) |=> ovf_q);

    // R11: overflow only rises after a push attempt
    a_r11_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(push_en));

endmodule

// File: rtl/spi_txq_ctrl.sv
`timescale 1ns/1ps
module spi_txq_ctrl
    import spi_txq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr_en,
    input  logic [15:0]       csr_wdata,
    output logic [15:0]       csr_rdata,
    input  logic              push_en,
    input  logic [DATA_W-1:0] push_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic [4:0]        fill_level,
    output logic              ovf,
    output logic              irq
);

    txq_state_e        state_q;
    logic              q_clear;
    logic              q_ovf_clr;
    logic [FILL_W-1:0] fill;

    spi_txq_csr u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (csr_wr_en),
        .wdata     (csr_wdata),
        .fill      (fill),
        .rdata     (csr_rdata),
        .irq       (irq),
        .state_q   (state_q),
        .q_clear   (q_clear),
        .q_ovf_clr (q_ovf_clr)
    );

    spi_txq_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .q_clear   (q_clear),
        .q_ovf_clr (q_ovf_clr),
        .push_en   (push_en),
        .push_data (push_data),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .fill      (fill),
        .ovf       (ovf)
    );

    assign fill_level = fill;

    // R9: the interrupt pin never rises without the flag in the readback
    a_r9_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (csr_rdata[BIT_FLAG] && csr_rdata[BIT_IEN]));

    // R3: readback count field tracks the fill output
    a_r3_field_matches: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[FILL_MSB:FILL_LSB] == fill_level);

endmodule

// File: tb/spi_txq_ctrl_bench.sv
`timescale 1ns/1ps
module spi_txq_ctrl_bench;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_wr = 1'b0;
    logic [15:0] b_wdata = '0;
    logic        b_push = 1'b0;
    logic [15:0] b_pdata = '0;
    logic        b_ready = 1'b0;
    logic [15:0] csr_rdata;
    logic        tx_valid;
    logic [15:0] tx_data;
    logic [4:0]  fill_level;
    logic        ovf;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Bench model of the requirements.
    bit          m15 = 1, m14 = 0, m13 = 1, mien = 0, mflag = 0, movf = 0;
    logic [4:0]  mthr = '0;
    logic [15:0] qm[$];

    always #2.5 clk = ~clk;

    spi_txq_ctrl u_spi_txq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_wr_en  (b_wr),
        .csr_wdata  (b_wdata),
        .csr_rdata  (csr_rdata),
        .push_en    (b_push),
        .push_data  (b_pdata),
        .tx_valid   (tx_valid),
        .tx_ready   (b_ready),
        .tx_data    (tx_data),
        .fill_level (fill_level),
        .ovf        (ovf),
        .irq        (irq)
    );

    task automatic check(input string tag);
        logic [15:0] exp_r;
        bit ev;
        bit bad;
        exp_r = {m15, m14, m13, 5'(qm.size()), mflag, 1'b0, mien, mthr};
        ev = m15 && m13 && (qm.size() > 0);
        bad = 0;
        n_chk++;
        if (csr_rdata !== exp_r) begin
            bad = 1;
            $display("FAIL %s csr_rdata actual=%h expected=%h", tag, csr_rdata, exp_r);
        end
        if (fill_level !== 5'(qm.size())) begin
            bad = 1;
            $display("FAIL %s fill_level actual=%0d expected=%0d", tag, fill_level, qm.size());
        end
        if (tx_valid !== ev) begin
            bad = 1;
            $display("FAIL %s tx_valid actual=%b expected=%b", tag, tx_valid, ev);
        end
        if (ev && (tx_data !== qm[0])) begin
            bad = 1;
            $display("FAIL %s tx_data actual=%h expected=%h", tag, tx_data, qm[0]);
        end
        if (irq !== (mflag && mien)) begin
            bad = 1;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, mflag && mien);
        end
        if (ovf !== movf) begin
            bad = 1;
            $display("FAIL %s ovf actual=%b expected=%b", tag, ovf, movf);
        end
        if (bad) n_fail++;
    endtask

    task automatic step(input string tag);
        bit run, vld, pop, pu, drop, n15, n14, n13, nien, clr, fl_n;
        logic [4:0] nthr;
        int cap;
        run  = m15 && m13;
        cap  = m14 ? DEPTH : 1;
        vld  = run && (qm.size() > 0);
        pop  = vld && b_ready;
        pu   = run && b_push && (qm.size() < cap);
        drop = run && b_push && !(qm.size() < cap);
        n15 = m15; n14 = m14; n13 = m13; nien = mien; nthr = mthr;
        if (b_wr) begin
            n15 = b_wdata[15]; n14 = b_wdata[14]; n13 = b_wdata[13];
            nien = b_wdata[5]; nthr = b_wdata[4:0];
        end
        clr  = b_wr && b_wdata[6];
        fl_n = clr ? 1'b0 : (mflag || (qm.size() <= int'(mthr)));
        if (!(n15 && n13)) begin
            qm.delete();
            movf = 0;
        end else begin
            if (run && (n14 != m14)) begin
                qm.delete();
            end else begin
                if (pop) void'(qm.pop_front());
                if (pu) qm.push_back(b_pdata);
            end
            if (drop) movf = 1;
        end
        m15 = n15; m14 = n14; m13 = n13; mien = nien; mthr = nthr; mflag = fl_n;
        @(posedge clk);
        #1;
        b_wr = 0;
        b_push = 0;
        check(tag);
    endtask

    task automatic cfg(input logic [15:0] w, input string tag);
        b_wr = 1;
        b_wdata = w;
        step(tag);
    endtask

    task automatic push(input logic [15:0] d, input string tag);
        b_push = 1;
        b_pdata = d;
        step(tag);
    endtask

    initial begin
        #400us;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #11;
        check("R1 reset value");
        @(negedge clk);
        rst_n = 1;
        step("R1 R7 flag after reset");

        // R2: full write; bit 6 clears, read-only fields ignored
        cfg(16'hFFFF, "R2 write all ones");
        step("R8 R9 flag re-sets, irq follows");
        cfg(16'hE044, "R8 clear with condition true");
        step("R7 flag re-arms");

        // R4 R3: fill to capacity
        for (int i = 0; i < DEPTH; i++) push(16'hA500 + 16'(i), "R4 R3 fill count");
        cfg(16'hE064, "R8 clear above threshold");
        step("R7 no set above threshold");
        push(16'hBEEF, "R11 push to full");
        step("R11 overflow sticky");
        b_ready = 1;
        push(16'hCAFE, "R11 full push dropped with pop");
        for (int i = 0; i < 20; i++) begin
            if (i % 3 == 0) push(16'h7000 + 16'(i), "R4 R13 push and pop");
            else step("R13 drain order");
        end
        b_ready = 0;

        // R5: queue reset holds
        push(16'h1111, "R4 refill");
        push(16'h2222, "R4 refill");
        cfg(16'hC064, "R5 queue reset");
        push(16'h3333, "R5 push ignored");
        step("R5 held");
        cfg(16'hE064, "R5 release");
        push(16'h4444, "R5 after release");

        // R6: channel reset keeps configuration
        push(16'h5555, "R4 refill");
        cfg(16'h6027, "R6 channel reset");
        push(16'h6666, "R6 push ignored");
        cfg(16'hE027, "R6 release");

        // R12 R10: mode flip and single-word mode
        push(16'h7777, "R4 deep push");
        push(16'h8888, "R4 deep push");
        cfg(16'hA027, "R12 flip to single flushes");
        push(16'h9999, "R10 single push");
        push(16'hAAAA, "R10 R11 single full drop");
        b_ready = 1;
        step("R13 single pop");
        push(16'hBBBB, "R10 single push and pop");
        step("R13 single drain");
        b_ready = 0;
        cfg(16'hA067, "R8 clear flag");
        cfg(16'hA027, "R8 write without clear bit");

        // R7: sweep of threshold against fill level
        for (int t = 0; t <= 16; t++) begin
            for (int n = 0; n <= 16; n++) begin
                cfg(16'hC040 | 16'(t), "R5 sweep hold");
                cfg(16'hE040 | 16'(t), "R7 sweep release");
                for (int k = 0; k < n; k++) push(16'(t * 32 + k), "R4 sweep fill");
                cfg(16'hE040 | 16'(t), "R8 sweep clear");
                step("R7 sweep threshold compare");
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule